// File: doc/BRIEF.md
# Tree Magnitude Comparator

This block compares two unsigned operands of equal width and reports whether the first is smaller or larger than the second. Equality is not a port of its own: it is shown by both result outputs being low. The comparison is built the way an adder's carry is built. Each bit pair is encoded into a "second operand wins here" term and a "bits match" term. These act as generate and propagate. Two-bit slices are formed first, then the terms are merged pairwise in a logarithmic prefix tree. The tree levels alternate between true and inverted polarity, and the last level is put back into true form before the outputs are formed. The "greater" result is the NOR of the final "less" and "equal" terms.

A build-time option chooses the merge structure. The first is a single binary tree over the whole word. The second is a hybrid: independent trees, each covering one byte, followed by one flat level that merges all the byte results at once. Width is a parameter. It must be a power of two and at least 8. Both outputs are registered: the result for the operands present at one rising clock edge appears after that edge, and a synchronous active-high reset clears both outputs.

Top module: `mag_cmp_tree`

## Requirements
- R1: The outputs change only at a rising clock edge. The result for the operands present at edge n is visible from edge n until edge n+1, so the latency is one cycle.
- R2: `lt_o` is 1 exactly when `a_i` is smaller than `b_i`, both read as unsigned integers.
- R3: `gt_o` is 1 exactly when `a_i` is larger than `b_i`, both read as unsigned integers.
- R4: When `a_i` equals `b_i`, both `lt_o` and `gt_o` are 0.
- R5: `lt_o` and `gt_o` are never 1 at the same time.
- R6: While `rst` is 1 at a rising edge, both outputs are 0 after that edge, whatever the operands are.
- R7: The most significant differing bit decides the result, whatever the lower bits hold. For example, a word with only bit W-1 set is larger than a word with every lower bit set.
- R8: Operands that differ in exactly one bit position, the LSB included, are ordered by that bit alone.
- R9: The full-tree build (`HYBRID`=0) and the byte-tree-plus-flat-merge build (`HYBRID`=1) give identical outputs for every operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the outputs register on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | W | First unsigned operand |
| b_i | input | W | Second unsigned operand |
| lt_o | output | 1 | Registered: first operand is smaller |
| gt_o | output | 1 | Registered: first operand is larger |

## Verification
A wrong merge or a polarity slip in the tree shows up one cycle after the offending operands. It appears as a wrong or doubled result for pairs whose first differing bit falls in the faulty subtree. Sweeping a single differing bit across every position, and pitting a lone high bit against all-ones below it, covers each tree node with a pair that only that node can decide. A fault in the equality chain appears as a spurious `gt_o` on equal operands. Running both builds side by side exposes any divergence between the byte-merge path and the full tree in the same cycle.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

  // Group result of a compare over a run of bits.
  typedef struct packed {
    logic lt;  // first operand smaller over this group
    logic eq;  // operands identical over this group
  } grp_t;

  // Carry-style combine: the upper group decides unless it is equal,
  // in which case the lower group decides.
  function automatic grp_t grp_merge(input grp_t hi, input grp_t lo);
    grp_t r;
    r.lt = hi.lt | (hi.eq & lo.lt);
    r.eq = hi.eq & lo.eq;
    return r;
  endfunction

endpackage

// File: rtl/cmp_encode.sv
module cmp_encode #(
  parameter int W = 64
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W/2-1:0] lt_o,
  output logic [W/2-1:0] eq_o
);
  localparam int SLICES = W / 2;

  // Per-bit terms: g = second operand wins at this bit, p = bits match.
  logic [W-1:0] g_bit;
  logic [W-1:0] p_bit;

  assign g_bit = ~a_i & b_i;
  assign p_bit = ~(a_i ^ b_i);

  // Two-bit slice: upper bit decides, lower bit only when upper matches.
  for (genvar j = 0; j < SLICES; j++) begin : g_slice
    assign lt_o[j] = g_bit[2*j+1] | (p_bit[2*j+1] & g_bit[2*j]);
    assign eq_o[j] = p_bit[2*j+1] & p_bit[2*j];
  end

endmodule

// File: rtl/cmp_tree.sv
module cmp_tree
  import mag_cmp_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0] lt_i,
  input  logic [N-1:0] eq_i,
  output logic         lt_o,
  output logic         eq_o
);
  localparam int LEVELS = $clog2(N);
  localparam int NODES  = 2 * N - 1;
  // Odd levels are held inverted; undo that on the last level if needed.
  localparam logic FIX_OUT = 1'(LEVELS % 2);

  // First node index of each level when all levels are packed in one vector.
  function automatic int lvl_base(input int l);
    return 2 * N - ((2 * N) >> l);
  endfunction

  logic [NODES-1:0] lt_n;
  logic [NODES-1:0] eq_n;

  assign lt_n[N-1:0] = lt_i;
  assign eq_n[N-1:0] = eq_i;

  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    localparam int   CNT    = N >> l;
    localparam int   IN_B   = lvl_base(l - 1);
    localparam int   OUT_B  = lvl_base(l);
    localparam logic IN_INV = 1'((l - 1) % 2);
    localparam logic OUT_INV = 1'(l % 2);

    for (genvar j = 0; j < CNT; j++) begin : g_node
      grp_t hi;
      grp_t lo;
      grp_t mg;
      // Bring both children to true polarity before merging.
      assign hi.lt = lt_n[IN_B + 2*j + 1] ^ IN_INV;
      assign hi.eq = eq_n[IN_B + 2*j + 1] ^ IN_INV;
      assign lo.lt = lt_n[IN_B + 2*j] ^ IN_INV;
      assign lo.eq = eq_n[IN_B + 2*j] ^ IN_INV;
      assign mg    = grp_merge(hi, lo);
      assign lt_n[OUT_B + j] = mg.lt ^ OUT_INV;
      assign eq_n[OUT_B + j] = mg.eq ^ OUT_INV;
    end
  end

  assign lt_o = lt_n[NODES-1] ^ FIX_OUT;
  assign eq_o = eq_n[NODES-1] ^ FIX_OUT;

endmodule

// File: rtl/cmp_flat.sv
module cmp_flat #(
  parameter int N = 8
) (
  input  logic [N-1:0] lt_i,
  input  logic [N-1:0] eq_i,
  output logic         lt_o,
  output logic         eq_o
);
  // win[k]: group k says "smaller" and every group above it is equal.
  logic [N-1:0] win;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      win[k] = lt_i[k];
      for (int j = k + 1; j < N; j++) begin
        win[k] = win[k] & eq_i[j];
      end
    end
  end

  assign lt_o = |win;
  assign eq_o = &eq_i;

endmodule

// File: rtl/mag_cmp_tree.sv
module mag_cmp_tree #(
  parameter int W      = 64,
  parameter bit HYBRID = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         lt_o,
  output logic         gt_o
);
  localparam int SLICES    = W / 2;
  localparam int BYTES     = W / 8;
  localparam int SL_PER_BY = 4;

  if ((W < 8) || ((W & (W - 1)) != 0)) begin : g_bad_width
    $error("mag_cmp_tree: W must be a power of two and at least 8");
  end

  logic [SLICES-1:0] s_lt;
  logic [SLICES-1:0] s_eq;
  logic              lt_d;
  logic              eq_d;

  cmp_encode #(.W(W)) u_enc (
    .a_i  (a_i),
    .b_i  (b_i),
    .lt_o (s_lt),
    .eq_o (s_eq)
  );

  if (!HYBRID) begin : g_full
    cmp_tree #(.N(SLICES)) u_tree (
      .lt_i (s_lt),
      .eq_i (s_eq),
      .lt_o (lt_d),
      .eq_o (eq_d)
    );
  end else begin : g_hyb
    logic [BYTES-1:0] by_lt;
    logic [BYTES-1:0] by_eq;

    for (genvar k = 0; k < BYTES; k++) begin : g_byte
      cmp_tree #(.N(SL_PER_BY)) u_btree (
        .lt_i (s_lt[k*SL_PER_BY +: SL_PER_BY]),
        .eq_i (s_eq[k*SL_PER_BY +: SL_PER_BY]),
        .lt_o (by_lt[k]),
        .eq_o (by_eq[k])
      );
    end

    cmp_flat #(.N(BYTES)) u_flat (
      .lt_i (by_lt),
      .eq_i (by_eq),
      .lt_o (lt_d),
      .eq_o (eq_d)
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lt_o <= 1'b0;
      gt_o <= 1'b0;
    end else begin
      lt_o <= lt_d;
      gt_o <= ~(lt_d | eq_d);
    end
  end

endmodule

// File: rtl/mag_cmp_tree_chk.sv
module mag_cmp_tree_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         lt_o,
  input logic         gt_o
);
  // Set once a non-reset edge has loaded the outputs.
  logic armed;

  always_ff @(posedge clk) begin
    armed <= ~rst;
  end

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(lt_o && gt_o)); // R5

  AST_LT_RESULT: assert property (@(posedge clk) disable iff (rst)
    armed |-> (lt_o == $past(a_i < b_i))); // R2

  AST_GT_RESULT: assert property (@(posedge clk) disable iff (rst)
    armed |-> (gt_o == $past(a_i > b_i))); // R3

  AST_EQUAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(a_i == b_i)) |-> (!lt_o && !gt_o)); // R4

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!lt_o && !gt_o)); // R6

endmodule

bind mag_cmp_tree mag_cmp_tree_chk #(.W(W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .a_i  (a_i),
  .b_i  (b_i),
  .lt_o (lt_o),
  .gt_o (gt_o)
);

// File: tb/mag_cmp_tree_test.sv
module mag_cmp_tree_test;
  localparam int W          = 64;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 50000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a   = '0;
  logic [W-1:0] b   = '0;
  logic         lt_f, gt_f, lt_h, gt_h;
  logic         prev_lt = 1'b0;
  logic         prev_gt = 1'b0;
  int           n_chk   = 0;
  int           n_fail  = 0;
  bit           done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mag_cmp_tree #(.W(W), .HYBRID(1'b0)) uut (
    .clk (clk), .rst (rst), .a_i (a), .b_i (b), .lt_o (lt_f), .gt_o (gt_f)
  );

  mag_cmp_tree #(.W(W), .HYBRID(1'b1)) uut_hyb (
    .clk (clk), .rst (rst), .a_i (a), .b_i (b), .lt_o (lt_h), .gt_o (gt_h)
  );

  task automatic check(input string req, input string what,
                       input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b (a=%h b=%h)",
               req, what, act, exp, a, b);
    end
  endtask

  // Drive at a falling edge, check at the next falling edge.
  task automatic vec(input logic [W-1:0] va, input logic [W-1:0] vb,
                     input string req);
    logic exp_lt, exp_gt;
    @(negedge clk);
    a = va;
    b = vb;
    #1;
    check("R1", "outputs hold before edge", {lt_f, gt_f}, {prev_lt, prev_gt});
    exp_lt = (va < vb);
    exp_gt = (va > vb);
    @(negedge clk);
    check("R2", "lt", {1'b0, lt_f}, {1'b0, exp_lt});
    check("R3", "gt", {1'b0, gt_f}, {1'b0, exp_gt});
    check("R5", "exclusive", {1'b0, lt_f & gt_f}, 2'b00);
    check("R9", "hybrid matches", {lt_h, gt_h}, {exp_lt, exp_gt});
    if (va == vb) check("R4", "equal gives both low", {lt_f, gt_f}, 2'b00);
    if (req != "") check(req, "corner", {lt_f, gt_f}, {exp_lt, exp_gt});
    prev_lt = exp_lt;
    prev_gt = exp_gt;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    logic [W-1:0] r;
    logic [W-1:0] s;
    // R6: reset state with unequal operands applied
    a = '0;
    b = {{(W-1){1'b0}}, 1'b1};
    repeat (3) @(negedge clk);
    check("R6", "reset full", {lt_f, gt_f}, 2'b00);
    check("R6", "reset hybrid", {lt_h, gt_h}, 2'b00);
    rst = 1'b0;
    prev_lt = 1'b1;  // a < b is loaded at the first edge out of reset
    prev_gt = 1'b0;
    @(negedge clk);

    vec('0, '0, "R4");
    vec('1, '1, "R4");
    vec('0, '1, "R2");
    vec('1, '0, "R3");
    // R7: top bit against all lower bits set
    vec({1'b1, {(W-1){1'b0}}}, {1'b0, {(W-1){1'b1}}}, "R7");
    vec({1'b0, {(W-1){1'b1}}}, {1'b1, {(W-1){1'b0}}}, "R7");
    vec({1'b0, {(W/2-1){1'b0}}, 1'b1, {(W/2-1){1'b0}}},
        {1'b0, {(W/2-1){1'b1}}, 1'b0, {(W/2-1){1'b1}}}, "R7");

    // R8: one differing bit at every position, both directions
    for (int k = 0; k < W; k++) begin
      r = {$urandom(), $urandom()};
      s = r ^ (W'(1) << k);
      vec(r, s, "R8");
      vec(s, r, "R8");
    end
    r = {$urandom(), $urandom()};
    vec(r & ~W'(1), r | W'(1), "R8");

    // R6: reset mid-stream clears a live result
    vec('0, '1, "R2");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R6", "mid reset full", {lt_f, gt_f}, 2'b00);
    check("R6", "mid reset hybrid", {lt_h, gt_h}, 2'b00);
    rst = 1'b0;
    prev_lt = 1'b1;
    prev_gt = 1'b0;
    @(negedge clk);

    // Random pairs, equal pairs and near pairs
    for (int i = 0; i < 200; i++) begin
      r = {$urandom(), $urandom()};
      s = {$urandom(), $urandom()};
      vec(r, s, "");
    end
    for (int i = 0; i < 40; i++) begin
      r = {$urandom(), $urandom()};
      vec(r, r, "R4");
      vec(r, r + W'($urandom_range(1, 3)), "");
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule